// File: doc/BRIEF.md
# Microcontroller Register Bus Interface

This block is the port through which an 8-bit microcontroller reaches a chip's internal registers. The controller supplies a chip select, separate read and write strobes and a 7-bit address. Data comes in on one 8-bit input and leaves on an 8-bit output together with an output enable, which a pad ring combines into one bidirectional bus. Two strap inputs fix the board wiring. One sets the chip-select polarity. The other chooses between direct addressing and indirect addressing. In indirect addressing, address bit 0 separates accesses to an address pointer from accesses to the register that pointer selects, and the pointer advances by one after each data access.

A small register file sits behind the port: a control register that holds the interrupt polarity, an interrupt enable register, an interrupt flag register and a bank of scratch registers. The upper half of the address space is a window onto buffer memory. An access into that window holds the wait output low until the memory side acknowledges it. The interrupt output is the OR of the enabled flags, driven at a programmable polarity.

Top module: `mcu_regport`

## Requirements
- R1: When `cs_pol_strap` is 1, chip select is active when `cs_in` is 0. When it is 0, chip select is active when `cs_in` is 1. A strobe without an active chip select reads nothing and writes nothing.
- R2: With `ind_mode_strap` at 0, the 7-bit `addr` selects the register directly.
- R3: With `ind_mode_strap` at 1, an access with `addr[0]`=0 reads or writes the 7-bit pointer, which reads back in bits 6:0 with bit 7 at 0. An access with `addr[0]`=1 reads or writes the register the pointer selects. `addr[6:1]` are ignored.
- R4: In indirect mode the pointer increases by one, modulo 128, at the end of each data access (read or write). Pointer accesses leave it unchanged.
- R5: Write data is taken from `data_i` on the clock edge that first samples `wr_n` high after it was low, while chip select is active.
- R6: `data_oe` is 1 only while chip select is active and `rd_n` is 0.
- R7: Control register bit 0 sets the interrupt polarity: 0 gives active low, 1 gives active high. It resets to 0, so `irq_out` is 1 after reset.
- R8: Flags at address 0x02 are set by any cycle with the matching `irq_src` bit high. Writing 1 to a flag bit clears it. `irq_out` is asserted while any flag that is enabled in address 0x01 is set.
- R9: A read or write with an effective address of 0x40 or above holds `wait_n` low and `buf_req` high until `buf_ack` is sampled. A read then returns the `buf_rdata` captured at that edge. A write presents `data_i` on `buf_wdata` with `buf_we` high and the address offset on `buf_addr`.
- R10: The map is 0x00 control, 0x01 enable (bits 3:0), 0x02 flags (bits 3:0), 0x08–0x0F scratch and 0x40–0x7F buffer window. Every other address reads 0x00 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_pol_strap | input | 1 | 1: chip select active low; 0: active high |
| ind_mode_strap | input | 1 | 1: indirect addressing; 0: direct |
| cs_in | input | 1 | Chip select from microcontroller |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 7 | Register address |
| data_i | input | 8 | Data from the bus pad |
| data_o | output | 8 | Data to the bus pad |
| data_oe | output | 1 | Pad output enable |
| irq_src | input | 4 | Interrupt event inputs |
| irq_out | output | 1 | Interrupt to microcontroller |
| wait_n | output | 1 | Wait, low while a buffer access is pending |
| buf_req | output | 1 | Buffer access pending |
| buf_we | output | 1 | Pending buffer access is a write |
| buf_addr | output | 6 | Offset in the buffer window |
| buf_wdata | output | 8 | Buffer write data |
| buf_rdata | input | 8 | Buffer read data |
| buf_ack | input | 1 | Buffer access complete |

## Verification
The assertions assume that the strobes and the address change synchronously with the clock, and that only one strobe is low at a time. They also assume that the address stays stable while a strobe is low, that the straps change only during reset, and that `buf_ack` comes only while `buf_req` is high. The bench drives every bus signal on the falling clock edge. It holds the address and chip select for one cycle past the strobe's trailing edge, changes the straps only with reset held, and answers buffer requests from a responder that acknowledges only an outstanding request. Each of the four strap combinations is swept under this discipline.

// File: rtl/mcu_regport.sv
module mcu_regport #(
  parameter int AW       = 7,
  parameter int DW       = 8,
  parameter int NSRC     = 4,
  parameter int SCR_BASE = 8,
  parameter int SCR_N    = 8,
  parameter int BUF_BASE = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs_pol_strap,
  input  logic            ind_mode_strap,
  input  logic            cs_in,
  input  logic            rd_n,
  input  logic            wr_n,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   data_i,
  output logic [DW-1:0]   data_o,
  output logic            data_oe,
  input  logic [NSRC-1:0] irq_src,
  output logic            irq_out,
  output logic            wait_n,
  output logic            buf_req,
  output logic            buf_we,
  output logic [$clog2((1<<AW)-BUF_BASE)-1:0] buf_addr,
  output logic [DW-1:0]   buf_wdata,
  input  logic [DW-1:0]   buf_rdata,
  input  logic            buf_ack
);
  localparam int BW = $clog2((1<<AW)-BUF_BASE);
  localparam int IW = $clog2(SCR_N);
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_EN   = AW'(1);
  localparam logic [AW-1:0] A_FLG  = AW'(2);
  localparam logic [AW-1:0] A_SLO  = AW'(SCR_BASE);
  localparam logic [AW-1:0] A_SHI  = AW'(SCR_BASE + SCR_N - 1);
  localparam logic [AW-1:0] A_BUF  = AW'(BUF_BASE);

  logic            cs_act, rd_act, wr_act, rd_q, wr_q, rd_end, wr_end;
  logic            ptr_acc, buf_hit, scr_hit, buf_done, wr_reg_end;
  logic [AW-1:0]   ptr, eff;
  logic [IW-1:0]   sidx;
  logic            pol;
  logic [NSRC-1:0] en, flags, wclr;
  logic [DW-1:0]   buf_q, rd_val;
  logic [DW-1:0]   scr [SCR_N];

  assign cs_act  = cs_pol_strap ? ~cs_in : cs_in;
  assign rd_act  = cs_act & ~rd_n;
  assign wr_act  = cs_act & ~wr_n;
  assign rd_end  = rd_q & cs_act & rd_n;
  assign wr_end  = wr_q & cs_act & wr_n;
  assign ptr_acc = ind_mode_strap & ~addr[0];
  assign eff     = ind_mode_strap ? ptr : addr;
  assign buf_hit = ~ptr_acc & (eff >= A_BUF);
  assign scr_hit = ~ptr_acc & (eff >= A_SLO) & (eff <= A_SHI);
  assign sidx    = IW'(eff - A_SLO);
  assign wr_reg_end = wr_end & ~ptr_acc & ~buf_hit;

  assign buf_req   = buf_hit & (rd_act | wr_act) & ~buf_done;
  assign buf_we    = wr_act;
  assign buf_addr  = BW'(eff - A_BUF);
  assign buf_wdata = data_i;
  assign wait_n    = ~buf_req;

  assign data_oe = rd_act;
  assign data_o  = rd_act ? rd_val : '0;
  assign irq_out = pol ? |(flags & en) : ~|(flags & en);
  assign wclr    = (wr_reg_end && eff == A_FLG) ? data_i[NSRC-1:0] : '0;

  always_comb begin
    rd_val = '0;
    if (ptr_acc)             rd_val = DW'(ptr);
    else if (buf_hit)        rd_val = buf_q;
    else if (scr_hit)        rd_val = scr[sidx];
    else if (eff == A_CTRL)  rd_val = DW'(pol);
    else if (eff == A_EN)    rd_val = DW'(en);
    else if (eff == A_FLG)   rd_val = DW'(flags);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q     <= 1'b0;
      wr_q     <= 1'b0;
      buf_done <= 1'b0;
      buf_q    <= '0;
    end else begin
      rd_q <= rd_act;
      wr_q <= wr_act;
      if (!(rd_act | wr_act))  buf_done <= 1'b0;
      else if (buf_req & buf_ack) buf_done <= 1'b1;
      if (buf_req & buf_ack) buf_q <= buf_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (ind_mode_strap) begin
      if (wr_end & ptr_acc)                 ptr <= data_i[AW-1:0];
      else if ((wr_end | rd_end) & ~ptr_acc) ptr <= ptr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol   <= 1'b0;
      en    <= '0;
      flags <= '0;
    end else begin
      flags <= (flags & ~wclr) | irq_src;
      if (wr_reg_end && eff == A_CTRL) pol <= data_i[0];
      if (wr_reg_end && eff == A_EN)   en  <= data_i[NSRC-1:0];
    end
  end

  for (genvar g = 0; g < SCR_N; g++) begin : g_scr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 scr[g] <= '0;
      else if (wr_reg_end && scr_hit && sidx == IW'(g)) scr[g] <= data_i;
    end
  end
endmodule

// File: rtl/mcu_regport_chk.sv
module mcu_regport_chk #(
  parameter int AW = 7,
  parameter int DW = 8,
  parameter int NSRC = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ind_mode_strap,
  input logic            rd_n,
  input logic            wr_n,
  input logic [DW-1:0]   data_i,
  input logic            data_oe,
  input logic [NSRC-1:0] irq_src,
  input logic            irq_out,
  input logic            wait_n,
  input logic            buf_ack,
  input logic [AW-1:0]   ptr,
  input logic            rd_end,
  input logic            wr_end,
  input logic            ptr_acc
);
  AST_OE_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> !rd_n); // R6
  AST_WAIT_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !wait_n |-> (!rd_n || !wr_n)); // R9
  AST_WAIT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (!wait_n && buf_ack) |=> wait_n); // R9
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_src == '0 && !(wr_n && !$past(wr_n))) |=> $stable(irq_out)); // R8
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ind_mode_strap && (rd_end || wr_end) && !ptr_acc) |=> ptr == AW'($past(ptr) + 1'b1)); // R4
  AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (ind_mode_strap && wr_end && ptr_acc) |=> ptr == $past(data_i[AW-1:0])); // R3
endmodule

bind mcu_regport mcu_regport_chk #(.AW(AW), .DW(DW), .NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .ind_mode_strap(ind_mode_strap), .rd_n(rd_n), .wr_n(wr_n),
  .data_i(data_i), .data_oe(data_oe), .irq_src(irq_src), .irq_out(irq_out),
  .wait_n(wait_n), .buf_ack(buf_ack), .ptr(ptr), .rd_end(rd_end), .wr_end(wr_end),
  .ptr_acc(ptr_acc)
);

// File: tb/sim_mcu_regport.sv
`timescale 1ns/1ps
module sim_mcu_regport;
  logic clk = 0, rst_n = 0, cs_pol = 0, ind = 0, cs_in = 0, rd_n = 1, wr_n = 1;
  logic [6:0] addr = 0;
  logic [7:0] data_i = 0, data_o, buf_wdata, buf_rdata;
  logic data_oe, irq_out, wait_n, buf_req, buf_we, buf_ack = 0;
  logic [3:0] irq_src = 0;
  logic [5:0] buf_addr;
  int checks = 0, errors = 0, bcnt = 0;
  bit done = 0;
  logic [5:0] last_waddr;
  logic [7:0] last_wdata;

  always #2.5 clk = ~clk;

  mcu_regport u0 (.clk(clk), .rst_n(rst_n), .cs_pol_strap(cs_pol), .ind_mode_strap(ind),
    .cs_in(cs_in), .rd_n(rd_n), .wr_n(wr_n), .addr(addr), .data_i(data_i), .data_o(data_o),
    .data_oe(data_oe), .irq_src(irq_src), .irq_out(irq_out), .wait_n(wait_n),
    .buf_req(buf_req), .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
    .buf_rdata(buf_rdata), .buf_ack(buf_ack));

  assign buf_rdata = {2'b00, buf_addr} ^ 8'hA5;

  initial forever begin
    @(negedge clk);
    if (buf_req) begin
      bcnt++;
      buf_ack = (bcnt == 2);
      if (buf_ack && buf_we) begin last_waddr = buf_addr; last_wdata = buf_wdata; end
    end else begin
      bcnt = 0;
      buf_ack = 0;
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic cs_lvl(bit on);
    return cs_pol ? ~on : on;
  endfunction

  task automatic wr_cyc(logic [6:0] a, logic [7:0] d, bit on = 1);
    @(negedge clk);
    addr = a; data_i = d; cs_in = cs_lvl(on); wr_n = 0;
    @(negedge clk);
    while (!wait_n) @(negedge clk);
    wr_n = 1;
    @(negedge clk);
    cs_in = cs_lvl(0);
  endtask

  task automatic rd_cyc(logic [6:0] a, output logic [7:0] d, output int waits, input bit on = 1);
    @(negedge clk);
    addr = a; cs_in = cs_lvl(on); rd_n = 0; waits = 0;
    #1;
    while (!wait_n) begin waits++; @(negedge clk); #1; end
    d = data_o;
    chk(data_oe == on, "R6 oe during read", data_oe, on);
    @(negedge clk);
    rd_n = 1;
    @(negedge clk);
    cs_in = cs_lvl(0);
  endtask

  task automatic reg_wr(logic [6:0] a, logic [7:0] d);
    if (ind) begin wr_cyc(7'h2A, {1'b0, a}); wr_cyc(7'h55, d); end
    else wr_cyc(a, d);
  endtask

  task automatic reg_rd(logic [6:0] a, output logic [7:0] d, output int waits);
    if (ind) begin wr_cyc(7'h00, {1'b0, a}); rd_cyc(7'h01, d, waits); end
    else rd_cyc(a, d, waits);
  endtask

  task automatic do_reset(bit p, bit m);
    @(negedge clk);
    rst_n = 0; cs_pol = p; ind = m; cs_in = cs_lvl(0); rd_n = 1; wr_n = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(irq_out == 1, "R7 reset irq idle high", irq_out, 1);
    chk(wait_n == 1, "R9 reset wait high", wait_n, 1);
    chk(data_oe == 0, "R6 reset bus released", data_oe, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int w;
    for (int cfg = 0; cfg < 4; cfg++) begin
      do_reset(cfg[0], cfg[1]);
      reg_rd(7'h00, d, w);
      chk(d == 8'h00, "R7 ctrl reset value", d, 0);
      // R10 R2 R3 scratch sweep
      for (int i = 0; i < 8; i++) reg_wr(7'(8 + i), 8'(8'h3C ^ (i * 37) ^ cfg));
      for (int i = 0; i < 8; i++) begin
        reg_rd(7'(8 + i), d, w);
        chk(d == 8'(8'h3C ^ (i * 37) ^ cfg), ind ? "R3 scratch indirect" : "R2 scratch direct", d, 8'(8'h3C ^ (i * 37) ^ cfg));
        chk(w == 0, "R9 no wait on register", w, 0);
      end
      // R10 unmapped
      reg_wr(7'h05, 8'hFF);
      reg_rd(7'h05, d, w);
      chk(d == 8'h00, "R10 unmapped 05", d, 0);
      reg_rd(7'h20, d, w);
      chk(d == 8'h00, "R10 unmapped 20", d, 0);
      // R1 R5 inactive chip select ignored
      if (ind) begin
        wr_cyc(7'h00, 8'h08);
        wr_cyc(7'h01, 8'hEE, 0);
        rd_cyc(7'h00, d, w);
        chk(d == 8'h08, "R1 pointer unchanged by deselected write", d, 8'h08);
      end else wr_cyc(7'h08, 8'hEE, 0);
      rd_cyc(ind ? 7'h01 : 7'h08, d, w, 0);
      chk(d == 8'h00, "R1 deselected read returns nothing", d, 0);
      reg_rd(7'h08, d, w);
      chk(d == 8'(8'h3C ^ cfg), "R5 deselected write ignored", d, 8'(8'h3C ^ cfg));
      if (ind) begin
        // R4 burst writes and reads
        wr_cyc(7'h2A, 8'h08);
        for (int i = 0; i < 8; i++) wr_cyc(7'h55, 8'(8'hC0 + i));
        rd_cyc(7'h00, d, w);
        chk(d == 8'h10, "R4 pointer after burst write", d, 8'h10);
        wr_cyc(7'h00, 8'h08);
        for (int i = 0; i < 8; i++) begin
          rd_cyc(7'h7F, d, w);
          chk(d == 8'(8'hC0 + i), "R4 burst read", d, 8'(8'hC0 + i));
        end
        rd_cyc(7'h00, d, w);
        chk(d == 8'h10, "R4 pointer after burst read", d, 8'h10);
        wr_cyc(7'h00, 8'h7F);
        rd_cyc(7'h01, d, w);
        chk(d == 8'(8'h3F ^ 8'hA5), "R9 buffer read at top", d, 8'(8'h3F ^ 8'hA5));
        rd_cyc(7'h00, d, w);
        chk(d == 8'h00, "R4 pointer wraps to 0", d, 0);
      end
      // R9 buffer window
      for (int k = 0; k < 64; k += 21) begin
        reg_rd(7'(64 + k), d, w);
        chk(d == (8'(k) ^ 8'hA5), "R9 buffer read data", d, 8'(k) ^ 8'hA5);
        chk(w > 0, "R9 wait asserted on buffer read", w, 1);
      end
      reg_wr(7'h45, 8'(8'h9C ^ cfg));
      chk(last_waddr == 6'h05, "R9 buffer write address", last_waddr, 5);
      chk(last_wdata == 8'(8'h9C ^ cfg), "R9 buffer write data", last_wdata, 8'(8'h9C ^ cfg));
      // R7 R8 interrupts
      reg_wr(7'h01, 8'h0F);
      chk(irq_out == 1, "R8 no flag no irq", irq_out, 1);
      @(negedge clk); irq_src = 4'b0010;
      @(negedge clk); irq_src = 4'b0000; #1;
      chk(irq_out == 0, "R8 flag raises active-low irq", irq_out, 0);
      reg_rd(7'h02, d, w);
      chk(d == 8'h02, "R8 flag readback", d, 2);
      reg_wr(7'h00, 8'h01);
      chk(irq_out == 1, "R7 active-high polarity", irq_out, 1);
      reg_wr(7'h01, 8'h00);
      chk(irq_out == 0, "R8 masked flag", irq_out, 0);
      reg_wr(7'h01, 8'h0F);
      chk(irq_out == 1, "R8 unmasked flag", irq_out, 1);
      reg_wr(7'h02, 8'h01);
      chk(irq_out == 1, "R8 clear of other bit keeps irq", irq_out, 1);
      reg_wr(7'h02, 8'h02);
      chk(irq_out == 0, "R8 write-one clear", irq_out, 0);
      reg_rd(7'h02, d, w);
      chk(d == 8'h00, "R8 flags cleared", d, 0);
      reg_wr(7'h00, 8'h00);
      chk(irq_out == 1, "R7 back to active low", irq_out, 1);
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule